// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block connects the four shared PCI interrupt lines to a legacy interrupt controller with sixteen level inputs. A device reports a level change on one of its four interrupt pins together with its slot number. The block rotates the pin by the slot to find the shared line, and it stores the new level of that line.

Four byte-wide routing registers, one per shared line, choose the controller input that each line drives. Software writes and reads these registers through a small indexed port. A routing value of sixteen or more disconnects the line. Each controller input is the logical OR of every shared line currently routed to it. The outputs are recomputed combinationally from the stored registers and levels, so a new routing value takes effect without waiting for a line to change.

A parameter picks the routing values loaded at reset. One choice disconnects all lines. The other pairs lines 0 and 1 onto input 10, and lines 2 and 3 onto input 11.

Top module: `pirq_router`

## Requirements
- R1: `line_sel_o` equals (`dev_pin_i` + `dev_slot_i` - 1) mod 4, combinationally, where pin value 0..3 stands for interrupt pins A..D.
- R2: When `dev_valid_i` is high at a rising clock edge, bit `line_sel_o` of `line_level_o` takes the value of `dev_level_i` after that edge. Without `dev_valid_i`, all line levels hold.
- R3: An active-low reset clears all four line levels, so `line_level_o` reads 0 and `irq_o` reads 0.
- R4: Reset loads routing register i with 0x80 when `RESET_PRESET` is `PRESET_OFF`. With `PRESET_PAIRED` it loads 0x0A for i = 0 and 1, and 0x0B for i = 2 and 3.
- R5: A write with `reg_we_i` high stores `reg_wdata_i` into the register selected by `reg_idx_i` at the clock edge. `reg_rdata_o` returns the stored value of the register selected by `reg_idx_i`, combinationally.
- R6: A shared line whose routing value is 16 or more (for example 0x10, 0x80 or 0x8F) drives no bit of `irq_o`.
- R7: Bit k of `irq_o` is the OR of the levels of all shared lines whose routing value equals k, for k in 0..15.
- R8: A change of routing value is reflected on `irq_o` right after the write edge, with no change of line level required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_slot_i | input | 5 | Slot number of the reporting device |
| dev_pin_i | input | 2 | Interrupt pin of the device, 0..3 for A..D |
| dev_valid_i | input | 1 | Level report strobe |
| dev_level_i | input | 1 | New level of the reported pin |
| line_sel_o | output | 2 | Shared line driven by the pin |
| line_level_o | output | 4 | Current level of each shared line |
| reg_we_i | input | 1 | Routing register write enable |
| reg_idx_i | input | 2 | Routing register index |
| reg_wdata_i | input | 8 | Routing write data |
| reg_rdata_o | output | 8 | Routing read data |
| irq_o | output | 16 | Level outputs to the interrupt controller |

## Verification
`line_sel_o` and `reg_rdata_o` are combinational, so their results are due in the same cycle as the stimulus. A level report or a register write is due one edge later, on `line_level_o` and `irq_o`. The driver applies each stimulus 2 ns after a rising edge. When a result is due, the driver queues the expected value: at once for combinational results, and after the next edge for registered ones. The monitor compares every queued item at the following falling edge, so each check samples in the cycle where the result must already be stable.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  typedef enum logic {
    PRESET_OFF    = 1'b0,
    PRESET_PAIRED = 1'b1
  } route_preset_e;

  // reset routing value of line idx for the selected preset
  function automatic logic [7:0] preset_route(route_preset_e p, int unsigned idx);
    logic [7:0] v;
    if (p == PRESET_PAIRED) v = 8'(32'h0A + idx / 2);
    else                    v = 8'h80;
    return v;
  endfunction

endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle #(
  parameter int unsigned SLOT_W    = 5,
  parameter int unsigned NUM_LINES = 4,
  localparam int unsigned LINE_W   = $clog2(NUM_LINES)
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [LINE_W-1:0] pin_i,
  output logic [LINE_W-1:0] line_o
);
  localparam int unsigned SUM_W = SLOT_W + 2;

  logic [SUM_W-1:0] sum;

  // slot - 1 folded in as + (NUM_LINES - 1) to stay non-negative
  always_comb begin
    sum    = SUM_W'(slot_i) + SUM_W'(pin_i) + SUM_W'(NUM_LINES - 1);
    line_o = LINE_W'(sum % SUM_W'(NUM_LINES));
  end
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_pkg::*;
#(
  parameter int unsigned   NUM_LINES    = 4,
  parameter int unsigned   DATA_W       = 8,
  parameter route_preset_e RESET_PRESET = PRESET_OFF,
  localparam int unsigned  LINE_W       = $clog2(NUM_LINES)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [LINE_W-1:0]                 idx_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic [DATA_W-1:0]                 rdata_o,
  output logic [NUM_LINES-1:0][DATA_W-1:0]  route_o
);
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(preset_route(RESET_PRESET, l));
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           q <= RST_VAL;
      else if (we_i && idx_i == LINE_W'(l))  q <= wdata_i;
    end

    assign route_o[l] = q;
  end

  assign rdata_o = route_o[idx_i];
endmodule

// File: rtl/pirq_line_state.sv
module pirq_line_state #(
  parameter int unsigned  NUM_LINES = 4,
  localparam int unsigned LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [LINE_W-1:0]    line_i,
  input  logic                 level_i,
  output logic [NUM_LINES-1:0] level_o
);
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_lvl
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            q <= 1'b0;
      else if (valid_i && line_i == LINE_W'(l)) q <= level_i;
    end
    assign level_o[l] = q;
  end
endmodule

// File: rtl/pirq_merge.sv
module pirq_merge #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned NUM_IRQS  = 16,
  parameter int unsigned DATA_W    = 8
) (
  input  logic [NUM_LINES-1:0][DATA_W-1:0] route_i,
  input  logic [NUM_LINES-1:0]             level_i,
  output logic [NUM_IRQS-1:0]              irq_o
);
  logic [NUM_LINES-1:0] live;

  // a line takes part only when routed to an existing input and asserted
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_live
    assign live[l] = level_i[l] && (route_i[l] < DATA_W'(NUM_IRQS));
  end

  for (genvar k = 0; k < NUM_IRQS; k++) begin : g_irq
    logic [NUM_LINES-1:0] hit;
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_hit
      assign hit[l] = live[l] && (route_i[l] == DATA_W'(k));
    end
    assign irq_o[k] = |hit;
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int unsigned   SLOT_W       = 5,
  parameter int unsigned   NUM_LINES    = 4,
  parameter int unsigned   NUM_IRQS     = 16,
  parameter int unsigned   DATA_W       = 8,
  parameter route_preset_e RESET_PRESET = PRESET_OFF,
  localparam int unsigned  LINE_W       = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SLOT_W-1:0]    dev_slot_i,
  input  logic [LINE_W-1:0]    dev_pin_i,
  input  logic                 dev_valid_i,
  input  logic                 dev_level_i,
  output logic [LINE_W-1:0]    line_sel_o,
  output logic [NUM_LINES-1:0] line_level_o,
  input  logic                 reg_we_i,
  input  logic [LINE_W-1:0]    reg_idx_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic [NUM_IRQS-1:0]  irq_o
);
  logic [NUM_LINES-1:0][DATA_W-1:0] route;

  pirq_swizzle #(.SLOT_W(SLOT_W), .NUM_LINES(NUM_LINES)) u_swizzle (
    .slot_i (dev_slot_i),
    .pin_i  (dev_pin_i),
    .line_o (line_sel_o)
  );

  pirq_line_state #(.NUM_LINES(NUM_LINES)) u_lines (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (dev_valid_i),
    .line_i  (line_sel_o),
    .level_i (dev_level_i),
    .level_o (line_level_o)
  );

  pirq_route_regs #(
    .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .RESET_PRESET(RESET_PRESET)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .idx_i   (reg_idx_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .route_o (route)
  );

  pirq_merge #(.NUM_LINES(NUM_LINES), .NUM_IRQS(NUM_IRQS), .DATA_W(DATA_W)) u_merge (
    .route_i (route),
    .level_i (line_level_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned NUM_IRQS  = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned LINE_W    = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 dev_valid_i,
  input logic                 dev_level_i,
  input logic [LINE_W-1:0]    line_sel_o,
  input logic [NUM_LINES-1:0] line_level_o,
  input logic                 reg_we_i,
  input logic [LINE_W-1:0]    reg_idx_i,
  input logic [DATA_W-1:0]    reg_wdata_i,
  input logic [DATA_W-1:0]    reg_rdata_o,
  input logic [NUM_IRQS-1:0]  irq_o
);
  AST_LEVEL_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_valid_i |=> line_level_o[$past(line_sel_o)] == $past(dev_level_i)); // R2

  AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_valid_i |=> $stable(line_level_o)); // R2

  AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (line_level_o == '0 && irq_o == '0)); // R3

  AST_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> (reg_idx_i != $past(reg_idx_i)) || (reg_rdata_o == $past(reg_wdata_i))); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_level_o == '0 |-> irq_o == '0); // R7

  AST_MERGE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(irq_o) <= $countones(line_level_o)); // R7
endmodule

bind pirq_router pirq_router_chk #(
  .NUM_LINES(NUM_LINES), .NUM_IRQS(NUM_IRQS), .DATA_W(DATA_W), .LINE_W(LINE_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dev_valid_i  (dev_valid_i),
  .dev_level_i  (dev_level_i),
  .line_sel_o   (line_sel_o),
  .line_level_o (line_level_o),
  .reg_we_i     (reg_we_i),
  .reg_idx_i    (reg_idx_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .irq_o        (irq_o)
);

// File: tb/pirq_router_tb.sv
module pirq_router_tb;
  import pirq_pkg::*;

  localparam int K_IRQ = 0, K_RD = 1, K_SEL = 2, K_LVL = 3, K_RDB = 4;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  dev_slot = '0;
  logic [1:0]  dev_pin = '0;
  logic        dev_valid = 1'b0, dev_level = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_idx = '0;
  logic [7:0]  reg_wdata = '0;
  logic [1:0]  line_sel, line_sel_b;
  logic [3:0]  line_level, line_level_b;
  logic [7:0]  reg_rdata, reg_rdata_b;
  logic [15:0] irq, irq_b;

  item_t q[$];
  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;
  logic [7:0] route_m[4];
  logic       lvl_m[4];

  always #5 clk = ~clk;

  pirq_router u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dev_slot_i(dev_slot), .dev_pin_i(dev_pin),
    .dev_valid_i(dev_valid), .dev_level_i(dev_level), .line_sel_o(line_sel),
    .line_level_o(line_level), .reg_we_i(reg_we), .reg_idx_i(reg_idx),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  pirq_router #(.RESET_PRESET(PRESET_PAIRED)) u_dut_b (
    .clk_i(clk), .rst_ni(rst_n), .dev_slot_i(dev_slot), .dev_pin_i(dev_pin),
    .dev_valid_i(1'b0), .dev_level_i(1'b0), .line_sel_o(line_sel_b),
    .line_level_o(line_level_b), .reg_we_i(1'b0), .reg_idx_i(reg_idx),
    .reg_wdata_i(8'h00), .reg_rdata_o(reg_rdata_b), .irq_o(irq_b)
  );

  function automatic logic [15:0] model_irq();
    logic [15:0] r = '0;
    for (int l = 0; l < 4; l++)
      if (lvl_m[l] && route_m[l] < 8'd16) r[route_m[l][3:0]] = 1'b1;
    return r;
  endfunction

  function automatic logic [3:0] model_lvl();
    return {lvl_m[3], lvl_m[2], lvl_m[1], lvl_m[0]};
  endfunction

  task automatic push(int k, logic [15:0] e, string r);
    item_t it;
    it.kind = k; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic model_reset();
    for (int l = 0; l < 4; l++) begin route_m[l] = 8'h80; lvl_m[l] = 1'b0; end
  endtask

  task automatic wr(logic [1:0] idx, logic [7:0] val, string r);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = val;
    tick();
    reg_we = 1'b0;
    route_m[idx] = val;
    push(K_RD, {8'h00, val}, "R5");
    push(K_IRQ, model_irq(), r);
    tick();
  endtask

  task automatic rd(logic [1:0] idx);
    reg_idx = idx;
    push(K_RD, {8'h00, route_m[idx]}, "R5");
    tick();
  endtask

  task automatic report(int slot, int pin, logic lv, string r);
    int ln;
    dev_slot = 5'(slot); dev_pin = 2'(pin); dev_level = lv; dev_valid = 1'b1;
    tick();
    dev_valid = 1'b0;
    ln = (pin + slot + 3) % 4;
    lvl_m[ln] = lv;
    push(K_LVL, {12'h000, model_lvl()}, "R2");
    push(K_IRQ, model_irq(), r);
    tick();
  endtask

  task automatic check_reset_state(string r);
    push(K_LVL, 16'h0000, r);
    push(K_IRQ, 16'h0000, r);
    tick();
    for (int i = 0; i < 4; i++) begin
      reg_idx = 2'(i);
      push(K_RD, 16'h0080, "R4");
      push(K_RDB, (i < 2) ? 16'h000A : 16'h000B, "R4");
      tick();
    end
  endtask

  // monitor: pops every queued item at the falling edge and compares
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = q.pop_front();
        case (it.kind)
          K_IRQ:   act = irq;
          K_RD:    act = {8'h00, reg_rdata};
          K_SEL:   act = {14'h0000, line_sel};
          K_LVL:   act = {12'h000, line_level};
          default: act = {8'h00, reg_rdata_b};
        endcase
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s kind %0d: actual %h expected %h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R3 R4: reset state
    check_reset_state("R3");

    // R1: every slot and pin rotation
    for (int s = 0; s < 32; s++) begin
      for (int p = 0; p < 4; p++) begin
        dev_slot = 5'(s); dev_pin = 2'(p);
        push(K_SEL, 16'((p + s + 3) % 4), "R1");
        tick();
      end
    end

    // R5 R6: disabled line stays silent while asserted
    report(2, 0, 1'b1, "R6");
    report(2, 0, 1'b0, "R6");

    // R5 R7: route line 0 to input 5 and raise it
    wr(2'd0, 8'd5, "R8");
    rd(2'd0);
    report(1, 0, 1'b1, "R7");
    // R7: line 1 also on input 5, merged by OR
    wr(2'd1, 8'd5, "R7");
    report(2, 0, 1'b1, "R7");
    report(1, 0, 1'b0, "R7");
    // R6 R8: disabling line 1 drops input 5 without a level change
    wr(2'd1, 8'h10, "R6");
    wr(2'd1, 8'h8F, "R6");
    // R8: boundary input 15
    wr(2'd1, 8'd15, "R8");
    // lines 2 and 3 to input 0
    wr(2'd2, 8'd0, "R8");
    report(3, 0, 1'b1, "R7");
    wr(2'd3, 8'd0, "R8");
    report(0, 0, 1'b1, "R7");
    report(3, 0, 1'b0, "R7");
    for (int i = 0; i < 4; i++) rd(2'(i));

    // R3: reset while lines are up
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    model_reset();
    check_reset_state("R3");
    report(0, 1, 1'b1, "R6");

    tick();
    tick();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule